// File: doc/BRIEF.md
# Audio Capture Sample FIFO

This block buffers recorded audio samples between an ADC's digital output and the system bus. Each time the ADC side pulses its sample strobe, the block stores that sample pair, or only the left sample in mono mode. Samples are kept as left first, then right. A DMA engine or software reads them one at a time from a 32-bit data register. The block formats each sample as a 16-bit or 24-bit value, placed either at the top of the word with zeros below or at the bottom of the word with sign extension.

A level-sensitive DMA request stays high while the request is enabled and the number of stored samples is greater than a 4-bit threshold. One control word holds the following:

- a self-clearing flush bit,
- the request enable,
- the sample width,
- mono mode,
- the threshold,
- the placement mode,
- the ADC digital enable,
- a 3-bit sample-rate code that is passed through to the decimator.

A status word reports the fill level, a sticky overrun flag and the request state.

Top module: `audcap_fifo`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, `rate_code` is 0, `drq` is low and `reg_rdata` is 0.
- R2: When a strobe arrives with the ADC enable set (control bit 28) and mono cleared, the left and right samples are stored. The fill count (status bits 5:0) rises by 2, and data reads (address 2) return the left sample before the right one, in arrival order.
- R3: With mono set (control bit 7), a strobe stores only the left sample and the count rises by 1.
- R4: While the ADC enable is 0, strobes store nothing and the count is unchanged.
- R5: `drq` is high exactly when the request enable (control bit 4) is 1 and the count is greater than the threshold (control bits 11:8). Status bit 9 mirrors `drq`.
- R6: A read word is formatted from the stored 24-bit sample s, using width bit 6 (1 = 24-bit, 0 = 16-bit using s[23:8]) and placement bit 24.
  - When bit 24 is 1, the value is MSB-aligned with zeros below.
  - When bit 24 is 0, the value sits in the low bits and is sign-extended.
- R7: Writing the control word with bit 0 set empties the FIFO in that cycle. Bit 0 always reads back as 0.
- R8: The FIFO holds 32 samples (16 pairs). A strobe whose samples do not all fit is dropped whole and sets the sticky overrun flag (status bit 8). Writing 1 to status bit 8 (address 1) clears the flag.
- R9: A data read from an empty FIFO returns 0 and leaves the count unchanged.
- R10: Control bits 31:29 appear on `rate_code`. All control fields except bit 0 read back as written (address 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle pulse marking a new sample pair |
| smp_left | input | 24 | Left ADC sample |
| smp_right | input | 24 | Right ADC sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 pops a sample) |
| reg_addr | input | 2 | 0 = control, 1 = status, 2 = data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| drq | output | 1 | DMA request level |
| rate_code | output | 3 | Sample-rate code for the decimator |

## Verification
The timing of each result is as follows:

- A control write takes effect at the clock edge that captures it. A flush therefore empties the FIFO on that same edge.
- A strobe updates the fill count at its capturing edge. `drq` then follows combinationally from the new count and control word, before the next edge.
- Read data is registered: it appears one cycle after the read strobe's edge.

The bench drives every input on the falling edge and holds it across one rising edge. It samples `drq` and `reg_rdata` on the following falling edge, which is exactly one register stage after the stimulus.

// File: rtl/audcap_pkg.sv
package audcap_pkg;

    parameter int SAMP_W = 24;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int B_FLUSH = 0;
    localparam int B_DRQEN = 4;
    localparam int B_W24   = 6;
    localparam int B_MONO  = 7;
    localparam int B_TRIG  = 8;
    localparam int B_MSB   = 24;
    localparam int B_ADCEN = 28;
    localparam int B_RATE  = 29;
    localparam int B_OVR   = 8;
    localparam int B_DRQ   = 9;

    typedef struct packed {
        logic [2:0] rate;
        logic       adc_en;
        logic       msb_fill;
        logic [3:0] trig;
        logic       mono;
        logic       w24;
        logic       drq_en;
    } cap_cfg_t;

    function automatic cap_cfg_t word_to_cfg(input logic [31:0] w);
        cap_cfg_t c;
        c.rate     = w[B_RATE +: 3];
        c.adc_en   = w[B_ADCEN];
        c.msb_fill = w[B_MSB];
        c.trig     = w[B_TRIG +: 4];
        c.mono     = w[B_MONO];
        c.w24      = w[B_W24];
        c.drq_en   = w[B_DRQEN];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input cap_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[B_RATE +: 3] = c.rate;
        w[B_ADCEN]     = c.adc_en;
        w[B_MSB]       = c.msb_fill;
        w[B_TRIG +: 4] = c.trig;
        w[B_MONO]      = c.mono;
        w[B_W24]       = c.w24;
        w[B_DRQEN]     = c.drq_en;
        return w;
    endfunction

endpackage

// File: rtl/audcap_ctrl_regs.sv
module audcap_ctrl_regs
    import audcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic [31:0] wdata,
    output cap_cfg_t    cfg,
    output logic        flush
);
    cap_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= '0;
        else if (wr_ctrl) cfg_q <= word_to_cfg(wdata);
    end

    assign cfg   = cfg_q;
    assign flush = wr_ctrl & wdata[B_FLUSH];
endmodule

// File: rtl/audcap_store.sv
module audcap_store #(
    parameter int SW    = 24,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  logic [SW-1:0] din0,
    input  logic [SW-1:0] din1,
    input  logic          pop,
    output logic [SW-1:0] head,
    output logic [CW-1:0] count,
    output logic          drop
);
    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt_q, room;
    logic          accept;

    assign room   = CW'(DEPTH) - cnt_q;
    assign accept = (push_n != 2'd0) && (CW'(push_n) <= room);
    assign drop   = (push_n != 2'd0) && !accept;

    always_ff @(posedge clk) begin
        if (accept && !flush) begin
            mem[wp] <= din0;
            if (push_n == 2'd2) mem[wp + AW'(1)] <= din1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            cnt_q <= '0;
        end else begin
            if (accept) wp <= wp + AW'(push_n);
            if (pop)    rp <= rp + AW'(1);
            cnt_q <= cnt_q + (accept ? CW'(push_n) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end

    assign head  = mem[rp];
    assign count = cnt_q;
endmodule

// File: rtl/audcap_align.sv
module audcap_align #(
    parameter int SW = 24
) (
    input  logic [SW-1:0] samp,
    input  logic          w24,
    input  logic          msb_fill,
    output logic [31:0]   word
);
    localparam int NW = 16;
    logic [NW-1:0] narrow;

    assign narrow = samp[SW-1 -: NW];

    always_comb begin
        unique case ({msb_fill, w24})
            2'b11:   word = {samp, {(32-SW){1'b0}}};
            2'b10:   word = {narrow, {(32-NW){1'b0}}};
            2'b01:   word = {{(32-SW){samp[SW-1]}}, samp};
            default: word = {{(32-NW){narrow[NW-1]}}, narrow};
        endcase
    end
endmodule

// File: rtl/audcap_fifo.sv
module audcap_fifo
    import audcap_pkg::*;
#(
    parameter int PAIRS = 16,
    localparam int DEPTH = 2 * PAIRS,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [SAMP_W-1:0] smp_left,
    input  logic [SAMP_W-1:0] smp_right,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              drq,
    output logic [2:0]        rate_code
);
    cap_cfg_t          cfg;
    logic              flush_now;
    logic [1:0]        push_n;
    logic              fifo_pop;
    logic [SAMP_W-1:0] head;
    logic [CW-1:0]     lvl;
    logic              drop;
    logic              ovr_q;
    logic [31:0]       fmt_word;
    logic [31:0]       stat_word;
    logic [31:0]       rd_mux;
    logic [31:0]       rdata_q;
    logic              adc_on;
    logic              drq_gate;
    logic [3:0]        trig_lvl;
    logic              rd_data;

    audcap_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (reg_wr && reg_addr == ADDR_CTRL),
        .wdata   (reg_wdata),
        .cfg     (cfg),
        .flush   (flush_now)
    );

    assign adc_on   = cfg.adc_en;
    assign drq_gate = cfg.drq_en;
    assign trig_lvl = cfg.trig;
    assign push_n   = (smp_stb && adc_on) ? (cfg.mono ? 2'd1 : 2'd2) : 2'd0;
    assign rd_data  = reg_rd && reg_addr == ADDR_DATA;
    assign fifo_pop = rd_data && lvl != '0;

    audcap_store #(.SW(SAMP_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush_now),
        .push_n (push_n),
        .din0   (smp_left),
        .din1   (smp_right),
        .pop    (fifo_pop),
        .head   (head),
        .count  (lvl),
        .drop   (drop)
    );

    audcap_align #(.SW(SAMP_W)) u_align (
        .samp     (head),
        .w24      (cfg.w24),
        .msb_fill (cfg.msb_fill),
        .word     (fmt_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ovr_q <= 1'b0;
        else if (drop && !flush_now)
            ovr_q <= 1'b1;
        else if (reg_wr && reg_addr == ADDR_STAT && reg_wdata[B_OVR])
            ovr_q <= 1'b0;
    end

    assign drq = drq_gate && (lvl > CW'(trig_lvl));

    always_comb begin
        stat_word = '0;
        stat_word[CW-1:0] = lvl;
        stat_word[B_OVR]  = ovr_q;
        stat_word[B_DRQ]  = drq;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: rd_mux = cfg_to_word(cfg);
            ADDR_STAT: rd_mux = stat_word;
            ADDR_DATA: rd_mux = fifo_pop ? fmt_word : 32'd0;
            default:   rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
    assign rate_code = cfg.rate;
endmodule

// File: rtl/audcap_fifo_chk.sv
module audcap_fifo_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          adc_on,
    input logic          drq_gate,
    input logic [3:0]    trig_lvl,
    input logic [CW-1:0] lvl,
    input logic          flush_now,
    input logic          rd_data,
    input logic          reg_rd,
    input logic          drq,
    input logic [31:0]   reg_rdata
);
    // R8: the fill level never passes the capacity
    a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
        lvl <= CW'(DEPTH));

    // R5: no request while the request enable is off
    a_r5_gate_off: assert property (@(posedge clk) disable iff (rst)
        !drq_gate |-> !drq);

    // R5: a raised request implies the level is above the threshold
    a_r5_above_trig: assert property (@(posedge clk) disable iff (rst)
        drq |-> lvl > CW'(trig_lvl));

    // R4: with the ADC off and no read or flush, the level holds
    a_r4_no_push_off: assert property (@(posedge clk) disable iff (rst)
        (!adc_on && !reg_rd && !flush_now) |=> lvl == $past(lvl));

    // R7: a flush leaves the FIFO empty
    a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush_now |=> lvl == '0);

    // R9: an empty data read returns zero
    a_r9_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data && lvl == '0) |=> reg_rdata == 32'd0);
endmodule

bind audcap_fifo audcap_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .adc_on    (adc_on),
    .drq_gate  (drq_gate),
    .trig_lvl  (trig_lvl),
    .lvl       (lvl),
    .flush_now (flush_now),
    .rd_data   (rd_data),
    .reg_rd    (reg_rd),
    .drq       (drq),
    .reg_rdata (reg_rdata)
);

// File: tb/audcap_fifo_tb.sv
module audcap_fifo_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [23:0] smp_left = '0, smp_right = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        drq;
    logic [2:0]  rate_code;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    audcap_fifo dut_i (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_left(smp_left),
        .smp_right(smp_right), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .drq(drq), .rate_code(rate_code)
    );

    typedef struct packed {
        logic [1:0]  fmt;
        logic [23:0] samp;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'b00, 24'h8ABCDE, 32'hFFFF8ABC},
        '{2'b00, 24'h123456, 32'h00001234},
        '{2'b01, 24'h8ABCDE, 32'hFF8ABCDE},
        '{2'b01, 24'h123456, 32'h00123456},
        '{2'b10, 24'h8ABCDE, 32'h8ABC0000},
        '{2'b10, 24'h123456, 32'h12340000},
        '{2'b11, 24'h8ABCDE, 32'h8ABCDE00},
        '{2'b11, 24'h123456, 32'h12345600}
    };

    function automatic logic [31:0] cw(input logic en, input logic dq, input logic w24,
                                       input logic mono, input logic [3:0] trig,
                                       input logic msb, input logic [2:0] rate,
                                       input logic fl);
        logic [31:0] w;
        w = '0;
        w[31:29] = rate; w[28] = en; w[24] = msb; w[11:8] = trig;
        w[7] = mono; w[6] = w24; w[4] = dq; w[0] = fl;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic strobe(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        smp_stb = 1'b1; smp_left = l; smp_right = r;
        @(posedge clk);
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'd0);
        chk("R1 drq", {31'd0, drq}, 32'd0);
        chk("R1 rate", {29'd0, rate_code}, 32'd0);
        rd(2'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(2'd1, d); chk("R1 status", d, 32'd0);

        // R10 readback and rate output; R7 flush bit reads 0
        wr(2'd0, 32'hB10007D1);
        rd(2'd0, d); chk("R10/R7 ctrl readback", d, 32'hB10007D0);
        chk("R10 rate_code", {29'd0, rate_code}, 32'd5);

        // R6 alignment table
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, cw(1, 0, VEC[i].fmt[0], 0, 4'd0, VEC[i].fmt[1], 3'd0, 1));
            strobe(VEC[i].samp, 24'h000000);
            rd(2'd2, d); chk($sformatf("R6 vec%0d left", i), d, VEC[i].exp);
            rd(2'd2, d); chk($sformatf("R6 vec%0d right", i), d, 32'd0);
        end

        // R4 ADC disabled
        wr(2'd0, cw(0, 0, 1, 0, 4'd0, 0, 3'd0, 1));
        strobe(24'h555555, 24'h666666);
        rd(2'd1, d); chk("R4 no push", d, 32'd0);

        // R2 stereo ordering
        wr(2'd0, cw(1, 0, 1, 0, 4'd0, 0, 3'd0, 1));
        strobe(24'h000011, 24'h000022);
        strobe(24'h000033, 24'h000044);
        rd(2'd1, d); chk("R2 count", d, 32'd4);
        rd(2'd2, d); chk("R2 first left", d, 32'h11);
        rd(2'd2, d); chk("R2 first right", d, 32'h22);
        rd(2'd2, d); chk("R2 second left", d, 32'h33);
        rd(2'd1, d); chk("R2 count after reads", d, 32'd1);

        // R3 mono
        wr(2'd0, cw(1, 0, 1, 1, 4'd0, 0, 3'd0, 1));
        strobe(24'h0000AA, 24'h0000BB);
        rd(2'd1, d); chk("R3 count", d, 32'd1);
        rd(2'd2, d); chk("R3 left only", d, 32'hAA);

        // R9 empty read
        rd(2'd2, d); chk("R9 empty data", d, 32'd0);
        rd(2'd1, d); chk("R9 count stays", d, 32'd0);

        // R5 request threshold at 3
        wr(2'd0, cw(1, 1, 1, 1, 4'd3, 0, 3'd0, 1));
        strobe(24'h1, 24'h0); strobe(24'h2, 24'h0); strobe(24'h3, 24'h0);
        chk("R5 at threshold", {31'd0, drq}, 32'd0);
        rd(2'd1, d); chk("R5 status at 3", d, 32'h003);
        strobe(24'h4, 24'h0);
        chk("R5 above threshold", {31'd0, drq}, 32'd1);
        rd(2'd1, d); chk("R5 status at 4", d, 32'h204);
        wr(2'd0, cw(1, 0, 1, 1, 4'd3, 0, 3'd0, 0));
        chk("R5 gate off", {31'd0, drq}, 32'd0);

        // R7 flush
        wr(2'd0, cw(1, 0, 1, 0, 4'd0, 0, 3'd0, 1));
        rd(2'd1, d); chk("R7 flushed", d, 32'd0);

        // R8 overrun
        for (int i = 0; i < 16; i++) strobe(24'(i + 1), 24'(i + 'h100));
        strobe(24'hAAAAAA, 24'hBBBBBB);
        rd(2'd1, d); chk("R8 full and overrun", d, 32'h120);
        rd(2'd2, d); chk("R8 oldest kept", d, 32'h1);
        rd(2'd1, d); chk("R8 sticky", d, 32'h11F);
        wr(2'd1, 32'h100);
        rd(2'd1, d); chk("R8 cleared", d, 32'h01F);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule